// File: doc/BRIEF.md
# Recovered Byte Strobe Generator

This block turns the bit stream of a multi-lane receiver into one byte strobe per lane. The strobe lives in the local clock domain, but on average it runs at the byte rate of the far-end transmitter. A deserializer front end delivers zero, one or two valid bits per lane in each local tick. Each lane collects those bits and, at most once per nominal byte interval, emits a strobe together with the aligned byte in the same registered cycle. No clock-recovery loop is involved: the lane shortens or stretches a single strobe interval by exactly one tick, depending on how many bits it holds when each byte boundary comes due.

Each lane runs a five-state machine. `ST_HALT` holds while the local PLL is unlocked or the block is in reset, and leaves on the first locked tick (transition *start*). `ST_ACCUM` counts the interval positions 0 to NOM_TICKS-3, then moves on (*advance*). `ST_EARLY` sits at position NOM_TICKS-2 and fires a short interval when at least BYTE_W+1 bits are held (*fire-short*); otherwise it steps to `ST_ONTIME` (*defer*). `ST_ONTIME` fires a nominal interval when at least BYTE_W bits are held (*fire-nominal*); otherwise it steps to `ST_LATE` (*stretch*). `ST_LATE` always fires, and marks the byte valid only if enough bits are held (*fire-long*). Every fire returns the lane to `ST_ACCUM` at position 0, and losing lock returns any state to `ST_HALT` (*drop*).

An output stage either passes each lane's own strobe through or aligns all lanes to lane 0. When aligned, every lane drives lane 0's strobe, and each lane's completed byte is held until the next lane-0 strobe delivers it. Alignment is requested by the lane-0 select input or by word-synchronization mode.

Top module: `rx_byte_strobe`

## Requirements
- R1: While `rst_n` or `pll_lock` is low, `stb_out` and `byte_vld` are all zero. When lock is regained, a lane restarts with no stored bits; the locked tick it first sees is spent leaving `ST_HALT` and its bits are discarded.
- R2: With exactly one valid bit per tick, each lane strobes every NOM_TICKS ticks (10 by default), and every byte is valid.
- R3: Within a lane field, `bits_cnt` gives the number of valid bits, and these are the low bits of the `bits_in` field, bit 0 arriving before bit 1. The first bit received becomes bit 0 of the byte.
- R4: If a lane holds at least BYTE_W+1 bits at interval position NOM_TICKS-2, it fires there, giving a short interval of NOM_TICKS-1 ticks.
- R5: If a lane holds fewer than BYTE_W bits at position NOM_TICKS-1, it fires at position NOM_TICKS, giving a long interval of NOM_TICKS+1 ticks. `byte_vld` is then high only if BYTE_W bits were held.
- R6: With no input bits at all, the strobe keeps running at long intervals and `byte_vld` stays low.
- R7: The strobe and its byte reach the ports two clock edges after the edge that samples the completing bits: one register in the lane and one in the output stage.
- R8: While `rec_en` is low, no strobes leave the block. The lanes keep counting, so the strobe timing continues unbroken when `rec_en` returns high.
- R9: With `sel_a` high, every `stb_out` bit equals lane 0's strobe, and each lane's valid bytes appear in order, with `byte_vld`, on lane-0 strobes.
- R10: With `wsync` high, the outputs are aligned to lane 0 exactly as in R9.
- R11: Input running one bit per 20 ticks fast is absorbed without overflow, and every completed byte is delivered.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Local reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pll_lock | input | 1 | Local PLL lock; low stops and clears all lanes |
| rec_en | input | 1 | Recovered-strobe mode enable for the outputs |
| sel_a | input | 1 | Broadcast lane 0's strobe to all lanes |
| wsync | input | 1 | Word-synchronization mode; aligns all lanes to lane 0 |
| bits_in | input | LANES*MAXB | Per-lane incoming bits, bit 0 first |
| bits_cnt | input | LANES*CNT_W | Per-lane count of valid bits this tick |
| stb_out | output | LANES | Per-lane byte strobe |
| byte_out | output | LANES*BYTE_W | Per-lane aligned byte |
| byte_vld | output | LANES | Byte on this strobe carries data |

## Verification
The bench builds the block with its defaults: four lanes, 10-bit bytes, a nominal interval of 10 ticks, at most two bits per tick and a 32-bit accumulator. With these values, a fast or slow input pattern of one bit per 20 ticks drives the short and long intervals within a few hundred cycles. A cross-lane mix (lane 0 nominal, lane 3 slow) makes alignment visibly differ from own-lane timing. The 32-bit accumulator leaves plenty of headroom above the two or three extra bits that the fast pattern builds up.

// File: rtl/rxbs_pkg.sv
package rxbs_pkg;
    typedef enum logic [2:0] {
        ST_HALT,
        ST_ACCUM,
        ST_EARLY,
        ST_ONTIME,
        ST_LATE
    } lane_st_t;
endpackage

// File: rtl/rxbs_lane.sv
module rxbs_lane
    import rxbs_pkg::*;
#(
    parameter int BYTE_W    = 10,
    parameter int NOM_TICKS = 10,
    parameter int MAXB      = 2,
    parameter int ACC_W     = 32,
    localparam int CNT_W    = $clog2(MAXB + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic [MAXB-1:0]   bits_i,
    input  logic [CNT_W-1:0]  cnt_i,
    output logic              stb_o,
    output logic [BYTE_W-1:0] byte_o,
    output logic              vld_o
);
    localparam int FILL_W = $clog2(ACC_W + 1);
    localparam int PH_W   = $clog2(NOM_TICKS + 1);

    lane_st_t          st, st_nxt;
    logic [PH_W-1:0]   ph, ph_nxt;
    logic [FILL_W-1:0] fill;
    logic [ACC_W-1:0]  acc;
    logic [FILL_W:0]   f_sum;
    logic [ACC_W-1:0]  acc_in;
    logic [MAXB-1:0]   in_mask;
    logic              enough, extra, fire, fire_vld;

    // incoming bits appended above the held ones
    always_comb begin
        for (int k = 0; k < MAXB; k++) begin
            in_mask[k] = (k < int'(cnt_i));
        end
        f_sum  = {1'b0, fill} + (FILL_W+1)'(cnt_i);
        acc_in = acc | (ACC_W'(bits_i & in_mask) << fill);
        enough = f_sum >= (FILL_W+1)'(BYTE_W);
        extra  = f_sum >= (FILL_W+1)'(BYTE_W + 1);
    end

    // next state and fire decision
    always_comb begin
        st_nxt   = st;
        ph_nxt   = ph;
        fire     = 1'b0;
        fire_vld = 1'b0;
        unique case (st)
            ST_HALT: begin
                st_nxt = ST_ACCUM;
                ph_nxt = '0;
            end
            ST_ACCUM: begin
                ph_nxt = ph + 1'b1;
                if (ph == PH_W'(NOM_TICKS - 3)) st_nxt = ST_EARLY;
            end
            ST_EARLY: begin
                if (extra) begin
                    fire     = 1'b1;
                    fire_vld = 1'b1;
                end else begin
                    st_nxt = ST_ONTIME;
                end
            end
            ST_ONTIME: begin
                if (enough) begin
                    fire     = 1'b1;
                    fire_vld = 1'b1;
                end else begin
                    st_nxt = ST_LATE;
                end
            end
            ST_LATE: begin
                fire     = 1'b1;
                fire_vld = enough;
            end
            default: st_nxt = ST_HALT;
        endcase
        if (fire) begin
            st_nxt = ST_ACCUM;
            ph_nxt = '0;
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st <= ST_HALT;
            ph <= '0;
        end else if (!run) begin
            st <= ST_HALT;
            ph <= '0;
        end else begin
            st <= st_nxt;
            ph <= ph_nxt;
        end
    end

    // accumulator and registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc    <= '0;
            fill   <= '0;
            stb_o  <= 1'b0;
            vld_o  <= 1'b0;
            byte_o <= '0;
        end else if (!run) begin
            acc    <= '0;
            fill   <= '0;
            stb_o  <= 1'b0;
            vld_o  <= 1'b0;
            byte_o <= '0;
        end else if (st == ST_HALT) begin
            stb_o <= 1'b0;
            vld_o <= 1'b0;
        end else begin
            stb_o <= fire;
            vld_o <= fire && fire_vld;
            if (fire && fire_vld) begin
                byte_o <= acc_in[BYTE_W-1:0];
                acc    <= acc_in >> BYTE_W;
                fill   <= FILL_W'(f_sum - (FILL_W+1)'(BYTE_W));
            end else begin
                acc  <= acc_in;
                fill <= FILL_W'(f_sum);
            end
        end
    end

    assert_no_overflow_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (run && st != ST_HALT) |-> (f_sum <= (FILL_W+1)'(ACC_W)));
    assert_min_spacing_R4: assert property (@(posedge clk) disable iff (!rst_n)
        stb_o |=> !stb_o);
    assert_late_fires_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (run && st == ST_LATE) |=> stb_o);
    assert_vld_on_stb_R5: assert property (@(posedge clk) disable iff (!rst_n)
        vld_o |-> stb_o);
    assert_halt_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (!stb_o && !vld_o));
endmodule

// File: rtl/rxbs_merge.sv
module rxbs_merge #(
    parameter int LANES  = 4,
    parameter int BYTE_W = 10
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    lock,
    input  logic                    rec_en,
    input  logic                    align,
    input  logic [LANES-1:0]        l_stb,
    input  logic [LANES-1:0]        l_vld,
    input  logic [LANES*BYTE_W-1:0] l_byte,
    output logic [LANES-1:0]        stb_o,
    output logic [LANES-1:0]        vld_o,
    output logic [LANES*BYTE_W-1:0] byte_o
);
    for (genvar gi = 0; gi < LANES; gi++) begin : g_out
        logic              stb_r, vld_r, pend;
        logic [BYTE_W-1:0] byte_r, hold;
        logic [BYTE_W-1:0] in_byte;
        logic              newb;

        assign in_byte = l_byte[gi*BYTE_W +: BYTE_W];
        assign newb    = l_stb[gi] & l_vld[gi];

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                stb_r  <= 1'b0;
                vld_r  <= 1'b0;
                pend   <= 1'b0;
                byte_r <= '0;
                hold   <= '0;
            end else if (!lock) begin
                stb_r  <= 1'b0;
                vld_r  <= 1'b0;
                pend   <= 1'b0;
                byte_r <= '0;
                hold   <= '0;
            end else if (!align) begin
                pend  <= 1'b0;
                stb_r <= rec_en && l_stb[gi];
                vld_r <= rec_en && newb;
                if (newb) byte_r <= in_byte;
            end else begin
                stb_r <= rec_en && l_stb[0];
                if (l_stb[0]) begin
                    vld_r <= rec_en && (newb || pend);
                    if (newb)      byte_r <= in_byte;
                    else if (pend) byte_r <= hold;
                    pend <= 1'b0;
                end else begin
                    vld_r <= 1'b0;
                    if (newb) begin
                        hold <= in_byte;
                        pend <= 1'b1;
                    end
                end
            end
        end

        assign stb_o[gi]                   = stb_r;
        assign vld_o[gi]                   = vld_r;
        assign byte_o[gi*BYTE_W +: BYTE_W] = byte_r;

        assert_vld_needs_stb_R9: assert property (@(posedge clk) disable iff (!rst_n)
            vld_r |-> stb_r);
        assert_lockstep_R9: assert property (@(posedge clk) disable iff (!rst_n)
            (align && lock) |=> (stb_r == stb_o[0]));
        assert_unlocked_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
            !lock |=> (!stb_r && !vld_r));
        assert_disabled_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
            !rec_en |=> !stb_r);
    end
endmodule

// File: rtl/rx_byte_strobe.sv
module rx_byte_strobe #(
    parameter int LANES     = 4,
    parameter int BYTE_W    = 10,
    parameter int NOM_TICKS = 10,
    parameter int MAXB      = 2,
    parameter int ACC_W     = 32,
    localparam int CNT_W    = $clog2(MAXB + 1)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    pll_lock,
    input  logic                    rec_en,
    input  logic                    sel_a,
    input  logic                    wsync,
    input  logic [LANES*MAXB-1:0]   bits_in,
    input  logic [LANES*CNT_W-1:0]  bits_cnt,
    output logic [LANES-1:0]        stb_out,
    output logic [LANES*BYTE_W-1:0] byte_out,
    output logic [LANES-1:0]        byte_vld
);
    logic [LANES-1:0]        l_stb, l_vld;
    logic [LANES*BYTE_W-1:0] l_byte;
    logic                    align;

    assign align = sel_a | wsync;

    for (genvar gi = 0; gi < LANES; gi++) begin : g_lane
        rxbs_lane #(
            .BYTE_W(BYTE_W), .NOM_TICKS(NOM_TICKS), .MAXB(MAXB), .ACC_W(ACC_W)
        ) u_lane (
            .clk    (clk),
            .rst_n  (rst_n),
            .run    (pll_lock),
            .bits_i (bits_in[gi*MAXB +: MAXB]),
            .cnt_i  (bits_cnt[gi*CNT_W +: CNT_W]),
            .stb_o  (l_stb[gi]),
            .byte_o (l_byte[gi*BYTE_W +: BYTE_W]),
            .vld_o  (l_vld[gi])
        );
    end

    rxbs_merge #(.LANES(LANES), .BYTE_W(BYTE_W)) u_merge (
        .clk    (clk),
        .rst_n  (rst_n),
        .lock   (pll_lock),
        .rec_en (rec_en),
        .align  (align),
        .l_stb  (l_stb),
        .l_vld  (l_vld),
        .l_byte (l_byte),
        .stb_o  (stb_out),
        .vld_o  (byte_vld),
        .byte_o (byte_out)
    );
endmodule

// File: tb/rx_byte_strobe_test.sv
module rx_byte_strobe_test;
    localparam int LANES = 4, BYTE_W = 10, NOM = 10, MAXB = 2, ACC_W = 32;
    localparam int CNT_W = $clog2(MAXB + 1);

    logic clk = 1'b0, rst_n = 1'b0, pll_lock = 1'b0, rec_en = 1'b0, sel_a = 1'b0, wsync = 1'b0;
    logic [LANES*MAXB-1:0]   bits_in = '0;
    logic [LANES*CNT_W-1:0]  bits_cnt = '0;
    logic [LANES-1:0]        stb_out, byte_vld;
    logic [LANES*BYTE_W-1:0] byte_out;

    rx_byte_strobe #(.LANES(LANES), .BYTE_W(BYTE_W), .NOM_TICKS(NOM), .MAXB(MAXB), .ACC_W(ACC_W))
    uut (.clk(clk), .rst_n(rst_n), .pll_lock(pll_lock), .rec_en(rec_en), .sel_a(sel_a),
         .wsync(wsync), .bits_in(bits_in), .bits_cnt(bits_cnt), .stb_out(stb_out),
         .byte_out(byte_out), .byte_vld(byte_vld));

    always #2.5 clk = ~clk;

    typedef struct { logic [BYTE_W-1:0] byt; bit vld; int due; } item_t;
    item_t sbq [LANES][$];
    bit    bq  [LANES][$];
    item_t pend_it [LANES];
    bit    pend_v [LANES];
    bit    run_m [LANES];
    int    pos_m [LANES], tk [LANES], pat [LANES];
    int    cyc = 0, errors = 0, checks = 0;
    bit    done = 0, align_m = 0;
    string align_req = "R9";
    int    last_stb [LANES], g9 [LANES], g10 [LANES], g11 [LANES];
    int    stb_cnt [LANES], vld_cnt [LANES], pushed [LANES], mis [LANES];

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(bit ok, string req, string what, int lane, longint act, longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: %s lane %0d actual=%0d expected=%0d", req, what, lane, act, exp);
        end
    endtask

    task automatic reset_stats();
        for (int i = 0; i < LANES; i++) begin
            last_stb[i] = -1; g9[i] = 0; g10[i] = 0; g11[i] = 0;
            stb_cnt[i] = 0; vld_cnt[i] = 0; pushed[i] = 0; mis[i] = 0;
        end
    endtask

    // driver: inputs for the next edge plus the expected result of that edge
    task automatic step();
        @(negedge clk);
        for (int i = 0; i < LANES; i++) begin
            int c;
            logic [MAXB-1:0] r;
            tk[i]++;
            case (pat[i])
                0: c = 1;
                1: c = (tk[i] % 20 == 19) ? 2 : 1;
                2: c = (tk[i] % 20 == 19) ? 0 : 1;
                default: c = 0;
            endcase
            r = MAXB'($urandom);
            bits_in[i*MAXB +: MAXB]   = r;
            bits_cnt[i*CNT_W +: CNT_W] = CNT_W'(c);
            if (pend_v[i] && pll_lock && rec_en) sbq[i].push_back(pend_it[i]);
            pend_v[i] = 0;
            if (!pll_lock || !rst_n) begin
                run_m[i] = 0;
                bq[i].delete();
            end else if (!run_m[i]) begin
                run_m[i] = 1;
                pos_m[i] = 0;
            end else begin
                int f;
                bit fire;
                for (int k = 0; k < c; k++) bq[i].push_back(r[k]);
                pushed[i] += c;
                f = bq[i].size();
                fire = (pos_m[i] == NOM - 2 && f >= BYTE_W + 1) ||
                       (pos_m[i] == NOM - 1 && f >= BYTE_W) || (pos_m[i] == NOM);
                if (fire) begin
                    pend_it[i].vld = (f >= BYTE_W);
                    pend_it[i].byt = '0;
                    if (pend_it[i].vld)
                        for (int k = 0; k < BYTE_W; k++) pend_it[i].byt[k] = bq[i].pop_front();
                    pend_it[i].due = cyc + 2;
                    pend_v[i] = 1;
                    pos_m[i] = 0;
                end else begin
                    pos_m[i]++;
                end
            end
        end
        @(posedge clk);
        #1;
    endtask

    task automatic steps(int n);
        for (int k = 0; k < n; k++) step();
    endtask

    task automatic relock(bit sa, bit ws);
        pll_lock = 0;
        steps(3);
        for (int i = 0; i < LANES; i++) sbq[i].delete();
        sel_a = sa; wsync = ws; align_m = sa | ws;
        align_req = ws ? "R10" : "R9";
        reset_stats();
        pll_lock = 1;
    endtask

    // monitor: pops the scoreboard as results appear
    always @(posedge clk) begin
        #1;
        for (int i = 0; i < LANES; i++) begin
            stb_cnt[i] += int'(stb_out[i]);
            vld_cnt[i] += int'(byte_vld[i]);
            if (!align_m) begin
                if (stb_out[i]) begin
                    if (last_stb[i] >= 0) begin
                        if (cyc - last_stb[i] == NOM - 1) g9[i]++;
                        else if (cyc - last_stb[i] == NOM) g10[i]++;
                        else if (cyc - last_stb[i] == NOM + 1) g11[i]++;
                    end
                    last_stb[i] = cyc;
                    if (sbq[i].size() == 0) begin
                        chk(0, "R2", "unexpected strobe", i, 1, 0);
                    end else begin
                        item_t it;
                        it = sbq[i].pop_front();
                        chk(it.due == cyc, "R7", "strobe cycle", i, cyc, it.due);
                        chk(byte_vld[i] == it.vld, "R5", "byte valid", i, byte_vld[i], it.vld);
                        if (it.vld)
                            chk(byte_out[i*BYTE_W +: BYTE_W] == it.byt, "R3", "byte value", i,
                                byte_out[i*BYTE_W +: BYTE_W], it.byt);
                    end
                end else if (sbq[i].size() > 0 && sbq[i][0].due < cyc) begin
                    chk(0, "R7", "missed strobe", i, 0, sbq[i][0].due);
                    void'(sbq[i].pop_front());
                end
            end else begin
                if (stb_out[i] != stb_out[0]) mis[i]++;
                if (byte_vld[i]) begin
                    while (sbq[i].size() > 0 && !sbq[i][0].vld) void'(sbq[i].pop_front());
                    if (sbq[i].size() == 0) begin
                        chk(0, align_req, "unexpected aligned byte", i, 1, 0);
                    end else begin
                        item_t it;
                        it = sbq[i].pop_front();
                        chk(byte_out[i*BYTE_W +: BYTE_W] == it.byt, align_req, "aligned byte", i,
                            byte_out[i*BYTE_W +: BYTE_W], it.byt);
                        chk(cyc >= it.due, align_req, "aligned byte early", i, cyc, it.due);
                    end
                end
            end
        end
    end

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run did not finish");
            summary();
            $finish;
        end
    end

    task automatic set_pat(int p0, int p1, int p2, int p3);
        pat[0] = p0; pat[1] = p1; pat[2] = p2; pat[3] = p3;
    endtask

    task automatic align_phase(bit sa, bit ws, string req);
        relock(sa, ws);
        set_pat(0, 0, 0, 2);
        steps(400);
        for (int i = 0; i < LANES; i++) begin
            chk(mis[i] == 0, req, "strobe differs from lane 0", i, mis[i], 0);
            chk(vld_cnt[i] >= 30, req, "aligned bytes delivered", i, vld_cnt[i], 30);
        end
    endtask

    initial begin
        reset_stats();
        for (int i = 0; i < LANES; i++) begin
            pend_v[i] = 0; run_m[i] = 0; pos_m[i] = 0; tk[i] = 0; pat[i] = 0;
        end
        // R1: reset and unlocked
        steps(5);
        chk(stb_out == '0, "R1", "strobes in reset", 0, stb_out, 0);
        chk(byte_vld == '0, "R1", "valid in reset", 0, byte_vld, 0);
        chk(byte_out == '0, "R1", "bytes in reset", 0, byte_out, 0);
        rst_n = 1; rec_en = 1;
        reset_stats();
        steps(30);
        for (int i = 0; i < LANES; i++)
            chk(stb_cnt[i] == 0, "R1", "strobes while unlocked", i, stb_cnt[i], 0);

        // R2: nominal rate
        relock(0, 0);
        set_pat(0, 0, 0, 0);
        steps(300);
        for (int i = 0; i < LANES; i++) begin
            chk(g10[i] >= 25, "R2", "nominal intervals", i, g10[i], 25);
            chk(g9[i] + g11[i] == 0, "R2", "off-nominal intervals", i, g9[i] + g11[i], 0);
        end

        // R4 and R11: fast far end
        reset_stats();
        set_pat(1, 1, 1, 1);
        steps(400);
        for (int i = 0; i < LANES; i++) begin
            chk(g9[i] > 0, "R4", "short intervals seen", i, g9[i], 1);
            chk(g11[i] == 0, "R4", "long intervals under fast input", i, g11[i], 0);
            chk(vld_cnt[i] * BYTE_W >= pushed[i] - 25, "R11", "bits delivered", i,
                vld_cnt[i] * BYTE_W, pushed[i] - 25);
        end

        // R5: slow far end
        reset_stats();
        set_pat(2, 2, 2, 2);
        steps(400);
        for (int i = 0; i < LANES; i++) begin
            chk(g11[i] > 0, "R5", "long intervals seen", i, g11[i], 1);
            chk(g9[i] == 0, "R5", "short intervals under slow input", i, g9[i], 0);
        end

        // R6: no input
        set_pat(3, 3, 3, 3);
        steps(30);
        reset_stats();
        steps(200);
        for (int i = 0; i < LANES; i++) begin
            chk(g11[i] >= 15, "R6", "free-running long strobes", i, g11[i], 15);
            chk(vld_cnt[i] == 0, "R6", "valid without input", i, vld_cnt[i], 0);
        end

        // R1: lock lost and regained
        set_pat(0, 1, 2, 0);
        steps(50);
        pll_lock = 0;
        step();
        reset_stats();
        steps(50);
        for (int i = 0; i < LANES; i++)
            chk(stb_cnt[i] == 0, "R1", "strobes after lock loss", i, stb_cnt[i], 0);
        pll_lock = 1;
        steps(100);
        for (int i = 0; i < LANES; i++)
            chk(stb_cnt[i] >= 8, "R1", "strobes after relock", i, stb_cnt[i], 8);

        // R8: recovered mode disabled
        rec_en = 0;
        step();
        reset_stats();
        steps(200);
        for (int i = 0; i < LANES; i++)
            chk(stb_cnt[i] == 0, "R8", "strobes while disabled", i, stb_cnt[i], 0);
        rec_en = 1;
        steps(100);
        for (int i = 0; i < LANES; i++)
            chk(stb_cnt[i] >= 8, "R8", "strobes after enable", i, stb_cnt[i], 8);

        // R9 and R10: alignment to lane 0
        align_phase(1, 0, "R9");
        align_phase(0, 1, "R10");

        done = 1;
        summary();
        $finish;
    end
endmodule